// File: doc/BRIEF.md
# Serial Test Loader for a Three-Channel DAC

This block is test logic for a three-channel, 10-bit DAC that is embedded in a larger chip. Few pins can be spared for test, so the block takes test codes one bit at a time. It uses one serial data pin and a serial clock that runs at ten times the DAC word rate. Ten consecutive bits make one word. When a word is complete, it moves into a holding register, and the block raises a one-cycle pulse.

A path-select input chooses the source of the DAC inputs. In normal mode, all three DAC channel inputs come from the host data bus. In test mode, the held word goes to the one channel that a 2-bit channel-select input names, and the other channels get code 0. All three channels share the same analog reference, so testing one channel at a time is enough to qualify the converter.

The whole block runs on the serial clock. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `dac_test_loader`

## Requirements
- R1: After reset the holding register is 0, `word_valid` is low and the bit counter restarts. In test mode the selected channel therefore shows code 0 until the first word is complete.
- R2: Serial bits are taken on rising clock edges while `test_mode` is high. The first bit taken becomes bit 9 (the MSB) of the word, and the tenth bit taken becomes bit 0.
- R3: On the edge that takes the tenth bit of a word, the word is loaded into the holding register. On that same edge `word_valid` goes high, and it stays high for exactly one clock.
- R4: The holding register changes only on a word boundary. Between boundaries, the test word on the DAC outputs stays constant.
- R5: In test mode, `chan_sel` picks the channel that receives the held word. The encodings are 2'b00 for channel 1 (`dac_data[9:0]`), 2'b01 for channel 2 (`dac_data[19:10]`) and 2'b10 for channel 3 (`dac_data[29:20]`).
- R6: In test mode, every channel that is not selected outputs code 0. `chan_sel` = 2'b11 selects no channel, so all three outputs are 0.
- R7: When `test_mode` is low, each channel passes its own slice of `host_data` straight through, with no clock delay. The slices line up with the `dac_data` slices.
- R8: While `test_mode` is low, the bit counter is held at zero and no word is completed. A partly shifted word is dropped, and framing starts again on the first bit after test mode is entered again.
- R9: Words can follow one another with no gap. In continuous test mode, `word_valid` pulses once every ten clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock (ten times the DAC word rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial test data, MSB first |
| test_mode | input | 1 | Path select: 1 = test word, 0 = host data |
| chan_sel | input | 2 | Channel under test: 00, 01, 10 = channels 1 to 3; 11 = none |
| host_data | input | 30 | Normal data; channel n uses bits [10n-1:10(n-1)] |
| dac_data | output | 30 | DAC channel inputs, sliced the same way as `host_data` |
| word_valid | output | 1 | One-cycle pulse when a new word is loaded |

## Verification
The bench builds the block with its default parameters: 10-bit words and three channels. With these values every channel-select code, including the unused one, can be reached, and the ten-cycle framing can be checked edge by edge. Words with all ones, all zeros and alternating bits expose bit-order and slice errors. Breaking off a word halfway through test mode shows whether framing restarts correctly.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CH1  = 2'b00,
    SEL_CH2  = 2'b01,
    SEL_CH3  = 2'b10,
    SEL_NONE = 2'b11
  } chan_sel_e;
endpackage

// File: rtl/dtl_shifter.sv
module dtl_shifter #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // next state: counter is parked at zero outside test mode
  always_comb begin
    sh_d  = sh_q;
    cnt_d = '0;
    if (shift_en) begin
      sh_d  = {sh_q[WORD_W-2:0], din};
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign last_o = shift_en && (cnt_q == CNT_LAST);
  assign word_o = {sh_q[WORD_W-2:0], din};
endmodule

// File: rtl/dtl_hold.sv
module dtl_hold #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] hold_q,
  output logic              valid_q
);
  logic [WORD_W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      valid_q <= load;
    end
  end
endmodule

// File: rtl/dtl_route.sv
module dtl_route #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned NUM_CH = 3
) (
  input  logic                       test_mode,
  input  logic [dtl_pkg::SEL_W-1:0]  chan_sel,
  input  logic [WORD_W-1:0]          test_word,
  input  logic [NUM_CH*WORD_W-1:0]   host_data,
  output logic [NUM_CH*WORD_W-1:0]   dac_data
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (chan_sel == dtl_pkg::SEL_W'(g));
    always_comb begin
      if (!test_mode)
        dac_data[g*WORD_W +: WORD_W] = host_data[g*WORD_W +: WORD_W];
      else if (hit)
        dac_data[g*WORD_W +: WORD_W] = test_word;
      else
        dac_data[g*WORD_W +: WORD_W] = '0;
    end
  end
endmodule

// File: rtl/dac_test_loader.sv
module dac_test_loader #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned NUM_CH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_din,
  input  logic                      test_mode,
  input  logic [1:0]                chan_sel,
  input  logic [NUM_CH*WORD_W-1:0]  host_data,
  output logic [NUM_CH*WORD_W-1:0]  dac_data,
  output logic                      word_valid
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [WORD_W-1:0] word_asm;
  logic              word_last;
  logic [WORD_W-1:0] hold_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dtl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .shift_en(test_mode), .din(ser_din),
    .word_o(word_asm), .last_o(word_last)
  );

  dtl_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .load(word_last), .word_i(word_asm),
    .hold_q(hold_word), .valid_q(word_valid)
  );

  dtl_route #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_route (
    .test_mode(test_mode), .chan_sel(chan_sel), .test_word(hold_word),
    .host_data(host_data), .dac_data(dac_data)
  );
endmodule

// File: rtl/dtl_checker.sv
module dtl_checker #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned NUM_CH = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     test_mode,
  input logic [1:0]               chan_sel,
  input logic [NUM_CH*WORD_W-1:0] host_data,
  input logic [NUM_CH*WORD_W-1:0] dac_data,
  input logic [WORD_W-1:0]        hold_word,
  input logic                     word_valid
);
  logic [NUM_CH-1:0] nz;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_nz
    assign nz[g] = |dac_data[g*WORD_W +: WORD_W];
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R3

  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(hold_word)); // R4

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> $onehot0(nz)); // R6

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && chan_sel == 2'b11) |-> (dac_data == '0)); // R6

  AST_HOST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (dac_data == host_data)); // R7

  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(test_mode)); // R8
endmodule

bind dac_test_loader dtl_checker #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_dtl_chk (
  .clk(clk), .rst_n(rst_sync_n), .test_mode(test_mode), .chan_sel(chan_sel),
  .host_data(host_data), .dac_data(dac_data), .hold_word(hold_word),
  .word_valid(word_valid)
);

// File: tb/dac_test_loader_bench.sv
module dac_test_loader_bench;
  localparam int W = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n, ser_din, test_mode;
  logic [1:0] chan_sel;
  logic [N*W-1:0] host_data, dac_data;
  logic word_valid;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dac_test_loader #(.WORD_W(W), .NUM_CH(N)) u_dac_test_loader (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .test_mode(test_mode),
    .chan_sel(chan_sel), .host_data(host_data), .dac_data(dac_data),
    .word_valid(word_valid)
  );

  task automatic chk(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] place(input logic [1:0] sel, input logic [W-1:0] w);
    logic [N*W-1:0] r = '0;
    for (int c = 0; c < N; c++) if (sel == 2'(c)) r[c*W +: W] = w;
    return r;
  endfunction

  // shift one word MSB first; old word must stay until the tenth bit (R4)
  task automatic send_word(input logic [W-1:0] w, input logic [W-1:0] prev);
    for (int i = W-1; i >= 0; i--) begin
      ser_din = w[i];
      @(negedge clk);
      if (i != 0) begin
        chk("R9 no early valid", {29'd0, word_valid}, '0);
        chk("R4 word stable", dac_data, place(chan_sel, prev));
      end
    end
    chk("R3 valid on tenth bit", {29'd0, word_valid}, 30'd1);
    chk("R2 word assembled MSB first", dac_data, place(chan_sel, w));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ser_din = 1'b0; test_mode = 1'b0; chan_sel = 2'b00;
    host_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid low", {29'd0, word_valid}, '0);
    test_mode = 1'b1;
    #1 chk("R1 hold cleared", dac_data, '0);
    test_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_host();
    host_data = {10'h155, 10'h2AA, 10'h3FF};
    #1 chk("R7 host pass", dac_data, {10'h155, 10'h2AA, 10'h3FF});
    host_data = {10'h001, 10'h200, 10'h0F0};
    #1 chk("R7 host pass immediate", dac_data, {10'h001, 10'h200, 10'h0F0});
    @(negedge clk);
  endtask

  task automatic t_words();
    chan_sel = 2'b00; test_mode = 1'b1;
    send_word(10'h3FF, 10'h000);
    send_word(10'h2A5, 10'h3FF);          // back to back (R9)
    @(negedge clk);
    chk("R3 valid one cycle", {29'd0, word_valid}, '0);
    test_mode = 1'b0; @(negedge clk); test_mode = 1'b1;
    chan_sel = 2'b01;
    send_word(10'h155, 10'h2A5);
    chan_sel = 2'b10;
    send_word(10'h000, 10'h155);
    send_word(10'h201, 10'h000);
  endtask

  task automatic t_select();
    for (int s = 0; s < 4; s++) begin
      chan_sel = 2'(s);
      #1 chk(s == 3 ? "R6 no channel" : "R5 R6 routing", dac_data, place(2'(s), 10'h201));
    end
    chan_sel = 2'b11;
    @(negedge clk);
    chk("R6 none selected", dac_data, '0);
  endtask

  task automatic t_abort();
    chan_sel = 2'b00;
    for (int i = 0; i < 4; i++) begin ser_din = 1'b1; @(negedge clk); end
    chk("R4 partial word ignored", dac_data, place(2'b00, 10'h201));
    test_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 no word in normal mode", {29'd0, word_valid}, '0);
    test_mode = 1'b1;
    send_word(10'h0C3, 10'h201);
  endtask

  initial begin
    t_reset();
    t_host();
    t_words();
    t_select();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule